// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable behavioural model of a pipelined synchronous static RAM in which reads and writes may be issued on every clock, in any mix, with no idle cycles between them. A read returns its word two active edges after the command. A write supplies its data two active edges after its address, in the same pipeline slot a read would use for its output. Because of this, the data bus never has to turn around between a read and a following write.

The host selects the part through three synchronous chip enables. A load/advance control either starts a new access at a fresh address or continues the previous access through a four-word burst. Per-lane write enables mask each 9-bit lane. A clock enable freezes the whole pipeline. The shared data bus is split into an input port, an output port and a drive-enable. An asynchronous output enable and a sleep input can force the bus off.

While a write is still waiting for its data, its address and lane mask are held in the pipeline. A read that immediately follows it to the same word takes the newly arriving bus data lane by lane, so it never returns stale contents.

Top module: `zbt_sram`

## Requirements
- R1: A load cycle (ld_n low) starts an access only when cs_a_n is low, cs_b is high and cs_c_n is low. Any other combination is a deselect, and no data is driven for it.
- R2: A read command captured at active edge k drives the addressed word on dq_out with dq_oe high between active edges k+1 and k+2.
- R3: The write data for a command at active edge k is taken from dq_in at active edge k+2. Lane enables are active low: lane_wr_n[0] guards bits 8:0 and lane_wr_n[1] guards bits 17:9. A lane whose enable is high keeps its stored bits.
- R4: Reads and writes may alternate on consecutive cycles with no idle cycles, and each read still returns correct data.
- R5: A read issued on the cycle right after a write to the same address returns the merged word, taking the enabled lanes from that write's data and the other lanes from the stored word.
- R6: While clk_en is low, no command is captured and all pipeline and output state holds, as though that edge had not occurred.
- R7: When oe_n is high, dq_oe is low at once, whatever the pipeline holds.
- R8: dq_oe is low in every cycle where write data is expected on the bus.
- R9: An advance cycle (ld_n high) repeats the previous access type at the next burst address. With burst_ilv low, the two low address bits count up from the load address modulo 4. With burst_ilv high, they are the load address bits XOR the count. An advance after a deselect stays deselected.
- R10: Sleep takes effect only at an edge where no access is pending in the first stage and the incoming cycle is a deselect. While asleep, commands are ignored and dq_oe is low. After leaving sleep, the bus stays undriven until a new read.
- R11: While rst_n is low and after its release, the pipeline is empty and dq_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | Clock qualifier; low freezes every register |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low: load new address; high: advance burst |
| wr_n | input | 1 | Low on a load cycle selects a write |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| dq_in | input | DW | Bus data into the block |
| dq_out | output | DW | Bus data out of the block |
| dq_oe | output | 1 | Bus drive enable |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request |

## Verification
The assertions assume that every control input holds a known value at each active edge once reset is released. They also assume that sleep changes only around deselect cycles, as the host is expected to arrange. The stimulus changes inputs only on the falling clock edge, always drives every control to 0 or 1, and raises sleep only while the pipeline can drain. Write data on dq_in is placed in the cycle two commands after its address, so the bench's own schedule models the late-write timing. Reads of locations that were never written are avoided, so no expected value depends on uninitialised storage.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 8,
  parameter int LW = 9,
  parameter int LANES = 2,
  localparam int DW = LW * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             ld_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  input  logic             oe_n,
  input  logic             sleep
);

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_t;

  op_t              last_op;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             sleep_q;
  logic             s1_v, s1_w, s2_v, s2_w;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_be, s2_be;
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    out_q;
  logic             out_v;
  logic [DW-1:0]    rd_word;

  wire             cs_ok   = !cs_a_n && cs_b && !cs_c_n;
  wire [1:0]       nxt_cnt = cnt_q + 2'd1;
  wire [1:0]       adv_lo  = burst_ilv ? (base_q[1:0] ^ nxt_cnt) : (base_q[1:0] + nxt_cnt);
  wire             cmd_v   = !sleep_q && (ld_n ? (last_op != OP_IDLE) : cs_ok);
  wire             cmd_w   = ld_n ? (last_op == OP_WR) : !wr_n;
  wire [AW-1:0]    cmd_a   = ld_n ? {base_q[AW-1:2], adv_lo} : addr;
  wire             fwd     = s2_v && s2_w && (s2_a == s1_a);

  assign dq_out = out_q;
  assign dq_oe  = out_v && !oe_n && !sleep_q;

  always_comb begin
    rd_word = mem[s1_a];
    for (int l = 0; l < LANES; l++)
      if (fwd && s2_be[l]) rd_word[l*LW +: LW] = dq_in[l*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
      s1_v    <= 1'b0;
      s1_w    <= 1'b0;
      s1_a    <= '0;
      s1_be   <= '0;
      s2_v    <= 1'b0;
      s2_w    <= 1'b0;
      s2_a    <= '0;
      s2_be   <= '0;
      out_v   <= 1'b0;
      out_q   <= '0;
    end else if (clk_en) begin
      if (sleep_q) begin
        last_op <= OP_IDLE;
      end else if (!ld_n) begin
        last_op <= !cs_ok ? OP_IDLE : (!wr_n ? OP_WR : OP_RD);
        base_q  <= addr;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= nxt_cnt;
      end
      sleep_q <= sleep_q ? sleep : (sleep && !s1_v && !cmd_v);
      s1_v  <= cmd_v;
      s1_w  <= cmd_w;
      s1_a  <= cmd_a;
      s1_be <= (cmd_v && cmd_w) ? ~lane_wr_n : '0;
      s2_v  <= s1_v;
      s2_w  <= s1_w;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      out_v <= s1_v && !s1_w;
      if (s1_v && !s1_w) out_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && s2_v && s2_w)
      for (int l = 0; l < LANES; l++)
        if (s2_be[l]) mem[s2_a][l*LW +: LW] <= dq_in[l*LW +: LW];
  end

  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ld_n && !cs_ok) |=> !s1_v);
  a_r2_read_out: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_v && !s1_w) |=> out_v);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(out_q) && $stable(out_v) && $stable(s1_v) && $stable(sleep_q)));
  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  a_r8_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_v && s1_w) |=> !out_v);
  a_r10_busy_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep_q && s1_v) |=> !sleep_q);
  a_r10_asleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> (!s1_v && !dq_oe));

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  localparam int AW = 8, LW = 9, LANES = 2, DW = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, clk_en, cs_a_n, cs_b, cs_c_n, ld_n, wr_n, burst_ilv, oe_n, sleep, dq_oe;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;

  zbt_sram #(.AW(AW), .LW(LW), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .ld_n(ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .burst_ilv(burst_ilv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .oe_n(oe_n), .sleep(sleep));

  typedef struct packed {
    logic [1:0]  k;
    logic [7:0]  a;
    logic [1:0]  ln;
    logic [17:0] wd;
    logic [17:0] ex;
  } vec_t;

  localparam int N = 16;
  localparam vec_t VEC [N] = '{
    '{2'd2, 8'h10, 2'b00, 18'h12345, 18'h0},
    '{2'd2, 8'h11, 2'b00, 18'h0ABCD, 18'h0},
    '{2'd1, 8'h10, 2'b11, 18'h0,     18'h12345},
    '{2'd2, 8'h10, 2'b01, 18'h3FE00, 18'h0},
    '{2'd1, 8'h10, 2'b11, 18'h0,     18'h3FF45},
    '{2'd1, 8'h11, 2'b11, 18'h0,     18'h0ABCD},
    '{2'd2, 8'h11, 2'b10, 18'h00077, 18'h0},
    '{2'd1, 8'h11, 2'b11, 18'h0,     18'h0AA77},
    '{2'd2, 8'h12, 2'b00, 18'h2A5A5, 18'h0},
    '{2'd1, 8'h12, 2'b11, 18'h0,     18'h2A5A5},
    '{2'd0, 8'h00, 2'b11, 18'h0,     18'h0},
    '{2'd1, 8'h10, 2'b11, 18'h0,     18'h3FF45},
    '{2'd2, 8'h10, 2'b11, 18'h00000, 18'h0},
    '{2'd1, 8'h10, 2'b11, 18'h0,     18'h3FF45},
    '{2'd0, 8'h00, 2'b11, 18'h0,     18'h0},
    '{2'd0, 8'h00, 2'b11, 18'h0,     18'h0}
  };

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [DW-1:0] exp, input string req);
    chk(dq_oe === 1'b1 && dq_out === exp, req, dq_oe ? dq_out : 18'h3FFFF, exp);
  endtask

  task automatic expect_z(input string req);
    chk(dq_oe === 1'b0, req, {17'b0, dq_oe}, 18'h0);
  endtask

  // kind: 0 deselect load, 1 read load, 2 write load, 3 advance
  task automatic cmd(input int kind, input logic [AW-1:0] a, input logic [1:0] ln, input logic [DW-1:0] bus);
    ld_n = (kind == 3);
    cs_a_n = (kind == 0);
    cs_b = 1'b1;
    cs_c_n = 1'b0;
    wr_n = !(kind == 2);
    addr = a;
    lane_wr_n = ln;
    dq_in = bus;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; oe_n = 1'b0; sleep = 1'b0; burst_ilv = 1'b0;
    cmd(0, '0, 2'b11, '0);
    tick; tick;
    expect_z("R11 in reset");
    rst_n = 1'b1;
    tick;
    expect_z("R11 after reset");

    for (int j = 0; j < N + 2; j++) begin
      logic [DW-1:0] bus;
      if (j >= 2) begin
        if (VEC[j-2].k == 2'd1) expect_rd(VEC[j-2].ex, "R2 R3 R4 R5 vector read");
        else expect_z("R8 R1 vector non-read");
      end
      bus = (j >= 2 && VEC[j-2].k == 2'd2) ? VEC[j-2].wd : 18'h15555;
      if (j < N) cmd(int'(VEC[j].k), VEC[j].a, VEC[j].ln, bus);
      else cmd(0, '0, 2'b11, bus);
      tick;
    end

    cmd(1, 8'h12, 2'b11, '0); tick;
    cmd(0, '0, 2'b11, '0); tick;
    oe_n = 1'b1; #1;
    expect_z("R7 oe_n high");
    oe_n = 1'b0; #1;
    expect_rd(18'h2A5A5, "R7 oe_n low");
    tick;

    cmd(1, 8'h11, 2'b11, '0); tick;
    clk_en = 1'b0; cmd(1, 8'h10, 2'b11, '0); tick;
    expect_z("R6 stall 1");
    tick;
    expect_z("R6 stall 2");
    clk_en = 1'b1; cmd(0, '0, 2'b11, '0); tick;
    expect_rd(18'h0AA77, "R6 resume");
    clk_en = 1'b0; tick;
    expect_rd(18'h0AA77, "R6 output held");
    clk_en = 1'b1; tick;
    expect_z("R6 no stray read");
    tick;
    expect_z("R6 no stray read later");

    for (int v = 0; v < 3; v++) begin
      cmd(1, 8'h10, 2'b11, '0);
      cs_a_n = (v == 0); cs_b = (v != 1); cs_c_n = (v == 2);
      tick;
      cmd(0, '0, 2'b11, '0); tick;
      expect_z("R1 partial select");
    end
    cmd(1, 8'h10, 2'b11, '0); tick;
    cmd(0, '0, 2'b11, '0); tick;
    expect_rd(18'h3FF45, "R1 full select");

    burst_ilv = 1'b0;
    cmd(2, 8'h22, 2'b00, '0); tick;
    cmd(3, '0, 2'b00, '0); tick;
    expect_z("R8 burst write phase");
    cmd(3, '0, 2'b00, 18'h00111); tick;
    cmd(3, '0, 2'b00, 18'h00222); tick;
    cmd(0, '0, 2'b11, 18'h00333); tick;
    cmd(0, '0, 2'b11, 18'h00444); tick;
    burst_ilv = 1'b1;
    cmd(1, 8'h21, 2'b11, '0); tick;
    cmd(3, '0, 2'b11, '0); tick;
    expect_rd(18'h00444, "R9 burst beat 0");
    cmd(3, '0, 2'b11, '0); tick;
    expect_rd(18'h00333, "R9 burst beat 1");
    cmd(3, '0, 2'b11, '0); tick;
    expect_rd(18'h00222, "R9 burst beat 2");
    cmd(0, '0, 2'b11, '0); tick;
    expect_rd(18'h00111, "R9 burst beat 3");
    cmd(0, '0, 2'b11, '0); tick;
    expect_z("R9 burst end");
    cmd(3, '0, 2'b11, '0); tick;
    cmd(3, '0, 2'b11, '0); tick;
    expect_z("R9 advance after deselect");
    cmd(0, '0, 2'b11, '0); tick;
    expect_z("R9 advance after deselect later");
    burst_ilv = 1'b0;

    sleep = 1'b1;
    cmd(1, 8'h10, 2'b11, '0); tick;
    cmd(0, '0, 2'b11, '0); tick;
    expect_rd(18'h3FF45, "R10 busy blocks sleep");
    cmd(0, '0, 2'b11, '0); tick;
    cmd(2, 8'h10, 2'b00, '0); tick;
    cmd(1, 8'h10, 2'b11, '0); tick;
    expect_z("R10 asleep");
    cmd(0, '0, 2'b11, '0); tick;
    expect_z("R10 asleep read ignored");
    sleep = 1'b0;
    cmd(0, '0, 2'b11, '0); tick;
    expect_z("R10 exit undriven");
    cmd(1, 8'h10, 2'b11, '0); tick;
    cmd(0, '0, 2'b11, '0); tick;
    expect_rd(18'h3FF45, "R10 write while asleep ignored");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule